// File: doc/BRIEF.md
# Hint-Steered Prefetch Line Manager

This block keeps the tag, valid and dirty state, plus the line contents, of a small set-associative data cache, and changes them in response to prefetch commands. Each command carries a line address and a 5-bit hint. The hint decides what happens. The line may be fetched from memory with the choice of way restricted. A present line may be written back and dropped, or written back and kept. A line may also be created without any memory read, either cleared to zero or keeping whatever the chosen way held before.

Only one command is handled at a time. A command is accepted when `busy` is low and `cmd_valid` is high. The block then runs the line lookup and issues at most two line-granular memory transactions: a write-back of a dirty victim, followed by the fill read. Each transaction uses a request that is held until it is acknowledged. `busy` drops once the command is finished.

Line address split: the low `log2(SETS)` bits of `cmd_addr` select the set and the remaining upper bits are the tag. With the defaults (8-bit line address, 4 sets) the set index is `cmd_addr[1:0]` and the tag is `cmd_addr[7:2]`. Write-back addresses are rebuilt in the same layout from the victim's tag and the set index.

Top module: `prefetch_hint_ctrl`

## Requirements
- R1: After reset `busy` and `mem_req` are low and every line is invalid, so the first fetch of any address issues a memory read.
- R2: Hints 0 and 1 on a miss read the line from memory (`mem_we`=0, `mem_addr` equal to the command address) and install it valid and clean with the returned data. On a hit they make no memory transaction.
- R3: Hints 4 and 5 install a missing line in way 0 only, so two streamed lines of one set displace each other. A hit makes no transaction.
- R4: Hints 6 and 7 install a missing line in a way other than way 0. A hit makes no transaction.
- R5: For hints 0, 1, 30 and 31, the way to replace is given by a per-set pointer. The pointer starts at way 0 after reset and, on each such allocation, moves to the way after the one used, wrapping after the last way. Hints 6 and 7 use the same pointer, but a value of 0 is read as way 1. Hints 4 and 5 leave the pointer unchanged.
- R6: When the way chosen for replacement is valid and dirty, its contents are first written to memory (`mem_we`=1) at the address formed from its own tag and the set. The fill read or line creation follows.
- R7: Hint 25 without the accelerated-write flag on a present line writes it back when dirty, then invalidates it. On a miss it does nothing.
- R8: Hint 25 with `cmd_accel`=1 on a present line always writes the line back and keeps it valid but clean. On a miss it does nothing.
- R9: Hint 30 on a miss creates the line with no memory read: valid, dirty, all data bits zero. On a hit it does nothing.
- R10: Hint 31 with `cfg_nz_en`=1 creates the line like hint 30 but keeps the way's previous data. With `cfg_nz_en`=0 it behaves exactly like hint 30, including the zero fill. The configuration bit is sampled at acceptance.
- R11: Every other hint code is accepted and has no effect on memory traffic or line state.
- R12: `busy` is high from the cycle after acceptance until the last transaction of the command is acknowledged. `cmd_valid` while busy is ignored. `mem_req` is only high while busy, and it holds with a stable address, direction and data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when `busy` is low |
| cmd_addr | input | ADDR_W | Line address of the command |
| cmd_hint | input | 5 | Hint code |
| cmd_accel | input | 1 | Line lies in an accelerated-write region |
| cfg_nz_en | input | 1 | Allows hint 31 to skip zero filling |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory transaction request, held until acknowledged |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W | Line address of the transaction |
| mem_wdata | output | LINE_W | Line data for a write-back |
| mem_ack | input | 1 | Transaction complete |
| mem_rdata | input | LINE_W | Line data returned with `mem_ack` for a read |

## Verification
The bench starts with directed sequences on a single set. These tell hit from miss, show streamed lines evicting each other in way 0, show retained lines avoiding way 0, and show the round-robin pointer cycling through all four ways. Next comes a sweep of all 32 hint codes under both configuration values, which separates the listed hints from the no-op codes and hint 31 from hint 30. A long pseudo-random mix of hints, accelerated-write flags and addresses over a few tags per set follows. This mix forces dirty evictions, stale-data creation and flushes of dirty, clean and absent lines. Every memory transaction is compared in order, for direction, address and write data, against a reference model kept in the bench.

// File: rtl/pfh_pkg.sv
package pfh_pkg;

    localparam int HINT_W = 5;

    localparam logic [HINT_W-1:0] H_FETCH_A   = 5'd0;
    localparam logic [HINT_W-1:0] H_FETCH_B   = 5'd1;
    localparam logic [HINT_W-1:0] H_STREAM_A  = 5'd4;
    localparam logic [HINT_W-1:0] H_STREAM_B  = 5'd5;
    localparam logic [HINT_W-1:0] H_KEEP_A    = 5'd6;
    localparam logic [HINT_W-1:0] H_KEEP_B    = 5'd7;
    localparam logic [HINT_W-1:0] H_DROP      = 5'd25;
    localparam logic [HINT_W-1:0] H_MAKE_ZERO = 5'd30;
    localparam logic [HINT_W-1:0] H_MAKE_RAW  = 5'd31;

    typedef enum logic [2:0] {
        CLS_NOP,
        CLS_FILL,
        CLS_STREAM,
        CLS_RETAIN,
        CLS_FLUSH,
        CLS_ZCREATE,
        CLS_RCREATE
    } hint_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WB,
        ST_RD,
        ST_MAKE,
        ST_CLEAN,
        ST_INVAL
    } ctl_state_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } line_flags_t;

    function automatic hint_cls_e classify(input logic [HINT_W-1:0] h, input logic nz_en);
        hint_cls_e c;
        case (h)
            H_FETCH_A, H_FETCH_B:   c = CLS_FILL;
            H_STREAM_A, H_STREAM_B: c = CLS_STREAM;
            H_KEEP_A, H_KEEP_B:     c = CLS_RETAIN;
            H_DROP:                 c = CLS_FLUSH;
            H_MAKE_ZERO:            c = CLS_ZCREATE;
            H_MAKE_RAW:             c = nz_en ? CLS_RCREATE : CLS_ZCREATE;
            default:                c = CLS_NOP;
        endcase
        return c;
    endfunction

    function automatic logic is_fetch(input hint_cls_e c);
        return (c == CLS_FILL) || (c == CLS_STREAM) || (c == CLS_RETAIN);
    endfunction

    function automatic logic is_create(input hint_cls_e c);
        return (c == CLS_ZCREATE) || (c == CLS_RCREATE);
    endfunction

endpackage

// File: rtl/pfh_line_store.sv
module pfh_line_store
    import pfh_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 6,
    parameter int LINE_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [WAY_W-1:0]  rd_way,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output line_flags_t       rd_flags,
    output logic [TAG_W-1:0]  rd_tag_o,
    output logic [LINE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  line_flags_t       wr_flags,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_data_en,
    input  logic [LINE_W-1:0] wr_data
);

    line_flags_t       flags_q [SETS][WAYS];
    logic [TAG_W-1:0]  tags_q  [SETS][WAYS];
    logic [LINE_W-1:0] data_q  [SETS][WAYS];
    logic [WAYS-1:0]   match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = flags_q[rd_set][g].valid && (tags_q[rd_set][g] == rd_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit      = |match;
    assign rd_flags = flags_q[rd_set][rd_way];
    assign rd_tag_o = tags_q[rd_set][rd_way];
    assign rd_data  = data_q[rd_set][rd_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    flags_q[s][w] <= '0;
                    tags_q[s][w]  <= '0;
                    data_q[s][w]  <= '0;
                end
            end
        end else if (wr_en) begin
            flags_q[wr_set][wr_way] <= wr_flags;
            tags_q[wr_set][wr_way]  <= wr_tag;
            if (wr_data_en) data_q[wr_set][wr_way] <= wr_data;
        end
    end

endmodule

// File: rtl/pfh_victim_pick.sv
module pfh_victim_pick
    import pfh_pkg::*;
#(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  hint_cls_e        cls,
    input  logic             advance,
    output logic [WAY_W-1:0] way
);

    logic [WAY_W-1:0] ptr_q [SETS];
    logic [WAY_W-1:0] ptr_cur;
    logic [WAY_W-1:0] ptr_nxt;

    assign ptr_cur = ptr_q[set_idx];

    always_comb begin
        case (cls)
            CLS_STREAM: way = '0;
            CLS_RETAIN: way = (ptr_cur == '0) ? WAY_W'(1) : ptr_cur;
            default:    way = ptr_cur;
        endcase
        ptr_nxt = (way == WAY_W'(WAYS - 1)) ? '0 : way + WAY_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (advance && (cls != CLS_STREAM)) begin
            ptr_q[set_idx] <= ptr_nxt;
        end
    end

endmodule

// File: rtl/prefetch_hint_ctrl.sv
module prefetch_hint_ctrl
    import pfh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int LINE_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - SET_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [4:0]        cmd_hint,
    input  logic              cmd_accel,
    input  logic              cfg_nz_en,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);

    ctl_state_e        state_q, next_q, look_next, after_wb;
    hint_cls_e         cls_q;
    logic              accel_q;
    logic [SET_W-1:0]  set_q;
    logic [TAG_W-1:0]  ltag_q;
    logic [WAY_W-1:0]  way_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [LINE_W-1:0] wdata_q;

    logic              hit;
    logic [WAY_W-1:0]  hit_way, vic_way, sel_way;
    line_flags_t       rd_flags;
    logic [TAG_W-1:0]  rd_tag_o;
    logic [LINE_W-1:0] rd_data;
    logic              vic_adv;

    logic              wr_en, wr_data_en, wr_valid;
    line_flags_t       wr_flags;
    logic [LINE_W-1:0] wr_data;

    pfh_line_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .rd_set(set_q), .rd_tag(ltag_q), .rd_way(sel_way),
        .hit(hit), .hit_way(hit_way),
        .rd_flags(rd_flags), .rd_tag_o(rd_tag_o), .rd_data(rd_data),
        .wr_en(wr_en), .wr_set(set_q), .wr_way(way_q),
        .wr_flags(wr_flags), .wr_tag(ltag_q),
        .wr_data_en(wr_data_en), .wr_data(wr_data)
    );

    pfh_victim_pick #(
        .SETS(SETS), .WAYS(WAYS)
    ) u_victim (
        .clk(clk), .rst(rst),
        .set_idx(set_q), .cls(cls_q), .advance(vic_adv), .way(vic_way)
    );

    assign sel_way = hit ? hit_way : vic_way;
    assign vic_adv = (state_q == ST_LOOK) && !hit && (is_fetch(cls_q) || is_create(cls_q));

    // decision taken in the lookup cycle
    always_comb begin
        look_next = ST_IDLE;
        after_wb  = ST_IDLE;
        if ((is_fetch(cls_q) || is_create(cls_q)) && !hit) begin
            after_wb  = is_fetch(cls_q) ? ST_RD : ST_MAKE;
            look_next = (rd_flags.valid && rd_flags.dirty) ? ST_WB : after_wb;
        end else if ((cls_q == CLS_FLUSH) && hit) begin
            if (accel_q) begin
                look_next = ST_WB;
                after_wb  = ST_CLEAN;
            end else if (rd_flags.dirty) begin
                look_next = ST_WB;
                after_wb  = ST_INVAL;
            end else begin
                look_next = ST_INVAL;
            end
        end
    end

    // line state update
    always_comb begin
        wr_en      = 1'b0;
        wr_flags   = '0;
        wr_data_en = 1'b0;
        wr_data    = mem_rdata;
        case (state_q)
            ST_RD: begin
                wr_en      = mem_ack;
                wr_flags   = '{valid: 1'b1, dirty: 1'b0};
                wr_data_en = 1'b1;
            end
            ST_MAKE: begin
                wr_en      = 1'b1;
                wr_flags   = '{valid: 1'b1, dirty: 1'b1};
                wr_data_en = (cls_q == CLS_ZCREATE);
                wr_data    = '0;
            end
            ST_CLEAN: begin
                wr_en    = 1'b1;
                wr_flags = '{valid: 1'b1, dirty: 1'b0};
            end
            ST_INVAL: begin
                wr_en    = 1'b1;
                wr_flags = '0;
            end
            default: ;
        endcase
    end

    assign wr_valid = wr_flags.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            next_q  <= ST_IDLE;
            cls_q   <= CLS_NOP;
            accel_q <= 1'b0;
            set_q   <= '0;
            ltag_q  <= '0;
            way_q   <= '0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        cls_q   <= classify(cmd_hint, cfg_nz_en);
                        accel_q <= cmd_accel;
                        set_q   <= cmd_addr[SET_W-1:0];
                        ltag_q  <= cmd_addr[ADDR_W-1:SET_W];
                        state_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    way_q   <= sel_way;
                    waddr_q <= {rd_tag_o, set_q};
                    wdata_q <= rd_data;
                    next_q  <= after_wb;
                    state_q <= look_next;
                end
                ST_WB: if (mem_ack) state_q <= next_q;
                ST_RD: if (mem_ack) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign mem_req   = (state_q == ST_WB) || (state_q == ST_RD);
    assign mem_we    = (state_q == ST_WB);
    assign mem_addr  = (state_q == ST_WB) ? waddr_q : {ltag_q, set_q};
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/prefetch_hint_ctrl_chk.sv
module prefetch_hint_ctrl_chk
    import pfh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINE_W = 32,
    parameter int WAY_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LINE_W-1:0] mem_wdata,
    input hint_cls_e         cls,
    input logic              wr_en,
    input logic              wr_valid,
    input logic [WAY_W-1:0]  wr_way
);

    assert_req_in_busy_R12: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_accept_busy_R12: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid) |=> busy);

    assert_stream_way0_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_valid && cls == CLS_STREAM) |-> (wr_way == '0));

    assert_retain_not_way0_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_valid && cls == CLS_RETAIN) |-> (wr_way != '0));

    assert_create_no_read_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && (cls == CLS_ZCREATE || cls == CLS_RCREATE)) |-> !(mem_req && !mem_we));

    assert_nop_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && cls == CLS_NOP) |-> (!mem_req && !wr_en));

endmodule

bind prefetch_hint_ctrl prefetch_hint_ctrl_chk #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .WAY_W(WAY_W)
) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cls(cls_q), .wr_en(wr_en), .wr_valid(wr_valid), .wr_way(way_q)
);

// File: tb/prefetch_hint_ctrl_tb.sv
module prefetch_hint_ctrl_tb;

    localparam int ADDR_W = 8;
    localparam int SETS   = 4;
    localparam int WAYS   = 4;
    localparam int LINE_W = 32;
    localparam int LAT    = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [4:0]        cmd_hint = '0;
    logic              cmd_accel = 1'b0;
    logic              cfg_nz_en = 1'b0;
    logic              busy, mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [LINE_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [LINE_W-1:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    prefetch_hint_ctrl #(
        .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)
    ) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_hint(cmd_hint), .cmd_accel(cmd_accel), .cfg_nz_en(cfg_nz_en),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [LINE_W-1:0] pat(input logic [ADDR_W-1:0] a);
        return {16'hC0DE, ~a, a};
    endfunction

    // memory responder and transaction log
    logic              lg_we   [8];
    logic [ADDR_W-1:0] lg_addr [8];
    logic [LINE_W-1:0] lg_data [8];
    int                n_log = 0;
    int                wcnt  = 0;

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wcnt == LAT) begin
                if (n_log < 8) begin
                    lg_we[n_log]   = mem_we;
                    lg_addr[n_log] = mem_addr;
                    lg_data[n_log] = mem_wdata;
                end
                n_log++;
                mem_rdata = mem_we ? '0 : pat(mem_addr);
                mem_ack   = 1'b1;
                wcnt      = 0;
            end else begin
                wcnt++;
            end
        end
    end

    // reference model
    logic [5:0]        m_tag [SETS][WAYS];
    bit                m_val [SETS][WAYS];
    bit                m_drt [SETS][WAYS];
    logic [LINE_W-1:0] m_dat [SETS][WAYS];
    int                m_ptr [SETS];
    logic              ex_we   [4];
    logic [ADDR_W-1:0] ex_addr [4];
    logic [LINE_W-1:0] ex_data [4];
    int                n_ex;

    task automatic push(input logic we, input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] d);
        ex_we[n_ex] = we; ex_addr[n_ex] = a; ex_data[n_ex] = d; n_ex++;
    endtask

    task automatic model_exec(input logic [4:0] h, input logic [ADDR_W-1:0] a,
                              input logic acc, input logic cfg);
        int s, hw, w;
        logic [5:0] t;
        bit fetch, create, zero;
        s = int'(a[1:0]); t = a[7:2]; hw = -1; n_ex = 0;
        for (int k = 0; k < WAYS; k++) if (m_val[s][k] && m_tag[s][k] == t && hw < 0) hw = k;
        fetch  = (h == 0 || h == 1 || h == 4 || h == 5 || h == 6 || h == 7);
        create = (h == 30 || h == 31);
        zero   = (h == 30) || (h == 31 && !cfg);
        if ((fetch || create) && hw < 0) begin
            if (h == 4 || h == 5) w = 0;
            else if (h == 6 || h == 7) begin
                w = (m_ptr[s] == 0) ? 1 : m_ptr[s];
                m_ptr[s] = (w + 1) % WAYS;
            end else begin
                w = m_ptr[s];
                m_ptr[s] = (w + 1) % WAYS;
            end
            if (m_val[s][w] && m_drt[s][w]) push(1'b1, {m_tag[s][w], 2'(s)}, m_dat[s][w]);
            m_val[s][w] = 1; m_tag[s][w] = t;
            if (fetch) begin
                push(1'b0, a, '0);
                m_drt[s][w] = 0; m_dat[s][w] = pat(a);
            end else begin
                m_drt[s][w] = 1;
                if (zero) m_dat[s][w] = '0;
            end
        end else if (h == 25 && hw >= 0) begin
            if (acc) begin
                push(1'b1, a, m_dat[s][hw]);
                m_drt[s][hw] = 0;
            end else begin
                if (m_drt[s][hw]) push(1'b1, a, m_dat[s][hw]);
                m_val[s][hw] = 0; m_drt[s][hw] = 0;
            end
        end
    endtask

    function automatic string req_of(input logic [4:0] h, input logic acc, input logic cfg);
        case (h)
            0, 1:    return "R2";
            4, 5:    return "R3";
            6, 7:    return "R4";
            25:      return acc ? "R8" : "R7";
            30:      return "R9";
            31:      return cfg ? "R10" : "R10/R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [4:0] h, input logic [ADDR_W-1:0] a, input logic acc,
                           input logic cfg, input bit poke, input string lbl);
        string rq;
        int g;
        rq = (lbl == "") ? req_of(h, acc, cfg) : lbl;
        model_exec(h, a, acc, cfg);
        n_log = 0;
        cmd_valid = 1'b1; cmd_hint = h; cmd_addr = a; cmd_accel = acc; cfg_nz_en = cfg;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R12", "busy after accept", 64'(busy), 64'd1);
        if (poke) begin
            // R12: a command offered while busy must be ignored
            cmd_valid = 1'b1; cmd_addr = a ^ 8'h3C; cmd_hint = 5'd0;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        g = 0;
        while (busy && g < 2000) begin
            @(negedge clk);
            g++;
        end
        check(g < 2000, "R12", "busy stuck", 64'(g), 64'd0);
        check(n_log == n_ex, rq, "transaction count", 64'(n_log), 64'(n_ex));
        for (int i = 0; i < n_ex && i < n_log; i++) begin
            check(lg_we[i] == ex_we[i] && lg_addr[i] == ex_addr[i],
                  ex_we[i] ? "R6/" : rq, ex_we[i] ? "write-back dir/addr" : "read dir/addr",
                  64'({lg_we[i], lg_addr[i]}), 64'({ex_we[i], ex_addr[i]}));
            if (ex_we[i])
                check(lg_data[i] == ex_data[i], rq, "write-back data",
                      64'(lg_data[i]), 64'(ex_data[i]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 0; m_drt[s][w] = 0; m_tag[s][w] = '0; m_dat[s][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", 64'(mem_req), 64'd0);

        // R1/R2: first fetch misses, repeat hits
        run_cmd(5'd0, 8'h05, 0, 0, 0, "R1");
        run_cmd(5'd0, 8'h05, 0, 0, 1, "R2");
        run_cmd(5'd1, 8'h09, 0, 0, 0, "R2");

        // R3: streamed lines of set 2 evict each other in way 0
        run_cmd(5'd4, 8'h12, 0, 0, 0, "R3");
        run_cmd(5'd5, 8'h16, 0, 0, 0, "R3");
        run_cmd(5'd0, 8'h12, 0, 0, 0, "R3");

        // R4: retained lines never use way 0
        run_cmd(5'd6, 8'h23, 0, 0, 0, "R4");
        run_cmd(5'd7, 8'h27, 0, 0, 0, "R4");
        run_cmd(5'd4, 8'h2B, 0, 0, 0, "R4");
        run_cmd(5'd6, 8'h23, 0, 0, 0, "R4");

        // R5/R6: round robin over set 0 with dirty created lines
        for (int i = 0; i < 6; i++) run_cmd(5'd30, 8'(8'h40 + 4 * i), 0, 0, 0, "R5");
        for (int i = 0; i < 4; i++) run_cmd(5'd0, 8'(8'h80 + 4 * i), 0, 0, 0, "R6");

        // R7/R8: flush of dirty, clean and absent lines
        run_cmd(5'd30, 8'hA1, 0, 0, 0, "R9");
        run_cmd(5'd25, 8'hA1, 1, 0, 0, "R8");
        run_cmd(5'd25, 8'hA1, 1, 0, 0, "R8");
        run_cmd(5'd25, 8'hA1, 0, 0, 0, "R7");
        run_cmd(5'd25, 8'hA1, 0, 0, 0, "R7");

        // R10: stale data kept only when enabled
        run_cmd(5'd0, 8'hB3, 0, 0, 0, "R10");
        run_cmd(5'd25, 8'hB3, 0, 0, 0, "R10");
        run_cmd(5'd31, 8'hB7, 0, 1, 0, "R10");
        run_cmd(5'd25, 8'hB7, 0, 0, 0, "R10");

        // sweep of every hint code with both configuration values
        for (int c = 0; c < 2; c++)
            for (int h = 0; h < 32; h++)
                run_cmd(5'(h), 8'(h * 5 + c), 1'(h[0] & c[0]), 1'(c), 0, "");

        // pseudo-random mix
        r = 32'h1234_5678;
        for (int i = 0; i < 900; i++) begin
            logic [4:0] hh;
            logic [4:0] tb5 [9];
            tb5 = '{5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd25, 5'd30, 5'd31};
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            hh = (r[3:0] < 4'd9) ? tb5[r[3:0]] : r[20:16];
            run_cmd(hh, {2'b0, 4'(r[9:6] % 4'd6), r[5:4]}, r[11] & r[12],
                    r[13], r[14] & r[15] & r[16], "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule